// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Update Mask

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each clock it takes an operation code, an accumulator-side operand, a second operand and the incoming carry. One clock later it presents the result, the next values of the negative, overflow, zero and carry flags, and a mask that says which of those four flags the operation is allowed to change. A separate strobe says whether the result is meant to be written back.

The surrounding datapath merges `flags_o` into its status register under `flag_we_o`, and writes `res_o` into the destination register only when `res_we_o` is high. The flag rules differ per operation. Bitwise operations touch only N and Z. The bit test and compare operations set flags but write nothing back. Increment and decrement leave carry alone. Rotates bring the old carry into the vacated bit.

The unary operations (increment, decrement, shifts and rotates) act on `a_i`. Decimal arithmetic is not supported.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `res_o`, `flags_o`, `flag_we_o` and `res_we_o` are all zero.
- R2: Outputs are registered. Inputs present at a rising edge set the outputs that follow that edge, and the outputs hold until the next edge.
- R3: Op 0 (AND), op 1 (OR) and op 2 (XOR) give the bitwise result of `a_i` and `b_i`. They set `flag_we_o`=4'b1010 (N and Z only) and `res_we_o`=1. Flag bit positions are N=3, V=2, Z=1, C=0.
- R4: Op 3 (bit test) sets Z when `a_i & b_i` is zero, N to `b_i[7]` and V to `b_i[6]`. It sets `flag_we_o`=4'b1110 and `res_we_o`=0.
- R5: Op 4 (add with carry) gives `a_i + b_i + c_i` modulo 256. C is the carry out. V is set when the signed sum is outside -128..127. It sets `flag_we_o`=4'b1111 and `res_we_o`=1.
- R6: Op 5 (subtract with carry) gives `a_i - b_i - (1 - c_i)` modulo 256. C=1 means no borrow. V is set on signed overflow. It sets `flag_we_o`=4'b1111 and `res_we_o`=1.
- R7: Op 6 (compare) sets C when `a_i >= b_i` unsigned, Z when the two are equal, and N to bit 7 of `a_i - b_i`. It ignores `c_i`, and it sets `flag_we_o`=4'b1011 and `res_we_o`=0.
- R8: Op 7 (increment) and op 8 (decrement) give `a_i` plus or minus one, wrapping at 8 bits. They set `flag_we_o`=4'b1010 and `res_we_o`=1.
- R9: Op 9 (shift left) and op 10 (logical shift right) move `a_i` one place and fill the vacated bit with 0. C takes the bit shifted out. They set `flag_we_o`=4'b1011 and `res_we_o`=1.
- R10: Op 11 (rotate left) and op 12 (rotate right) fill the vacated bit with `c_i`. C takes the bit shifted out. They set `flag_we_o`=4'b1011 and `res_we_o`=1.
- R11: For every operation except the bit test, N equals `res_o[7]` and Z equals (`res_o`==0) whenever their enable bits are set.
- R12: Op codes 13 to 15 are reserved. They produce `res_o`=0, `flag_we_o`=0 and `res_we_o`=0.
- R13: Any bit of `flags_o` whose `flag_we_o` bit is 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (0..12, 13..15 reserved) |
| a_i | input | 8 | Accumulator-side operand, also the source for unary operations |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Incoming carry |
| res_o | output | 8 | Result |
| flags_o | output | 4 | Next flag values {N,V,Z,C} |
| flag_we_o | output | 4 | Per-flag update enables {N,V,Z,C} |
| res_we_o | output | 1 | Result write-back strobe |

## Verification
Addition is driven with operand pairs that separate carry-out from signed overflow: 0x50+0x50 overflows without a carry, and 0xFF+0x01 carries to zero without overflow. Subtraction and compare are driven with equal, greater and smaller operands, and with opposite-sign pairs, so that borrow, Z, sign-based N and V each change on their own. Compare is also run with both carry-in values to show that carry-in is ignored. Shifts and rotates use both carry-in values on patterns whose end bits differ, which separates the zero fill from the carry fill and checks that the captured carry comes from the correct end. The bit test uses operands whose AND is zero while bits 7 and 6 of the second operand are set, which shows that N and V come from the operand and not from the AND result.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_BIT  = 4'd3,
        OP_ADC  = 4'd4,
        OP_SBC  = 4'd5,
        OP_CMP  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_ASL  = 4'd9,
        OP_LSR  = 4'd10,
        OP_ROL  = 4'd11,
        OP_ROR  = 4'd12,
        OP_RS13 = 4'd13,
        OP_RS14 = 4'd14,
        OP_RS15 = 4'd15
    } alu_op_e;

    localparam int FL_N = 3;
    localparam int FL_V = 2;
    localparam int FL_Z = 1;
    localparam int FL_C = 0;

    localparam logic [3:0] WE_NZ   = 4'b1010;
    localparam logic [3:0] WE_NVZ  = 4'b1110;
    localparam logic [3:0] WE_NZC  = 4'b1011;
    localparam logic [3:0] WE_ALL  = 4'b1111;
    localparam logic [3:0] WE_NONE = 4'b0000;

endpackage

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);

    always_comb begin
        case (op)
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = a & b;   // AND and bit test share the mask
        endcase
    end

endmodule

// File: rtl/alu8_adder.sv
`timescale 1ns/1ps
module alu8_adder
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           c_in,
    output logic [W-1:0]   res,
    output logic           c_out,
    output logic           v_out
);

    localparam int SW = W + 1;

    logic [W-1:0]  b_eff;
    logic          cin_eff;
    logic [SW-1:0] sum;

    // Pick the second addend and carry-in so that one adder serves all
    always_comb begin
        case (op)
            OP_SBC: begin b_eff = ~b;       cin_eff = c_in; end
            OP_CMP: begin b_eff = ~b;       cin_eff = 1'b1; end
            OP_INC: begin b_eff = '0;       cin_eff = 1'b1; end
            OP_DEC: begin b_eff = '1;       cin_eff = 1'b0; end
            default: begin b_eff = b;       cin_eff = c_in; end
        endcase
    end

    assign sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
    assign res   = sum[W-1:0];
    assign c_out = sum[W];
    assign v_out = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

endmodule

// File: rtl/alu8_shift.sv
`timescale 1ns/1ps
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic           c_in,
    output logic [W-1:0]   res,
    output logic           c_out
);

    logic fill;

    // Rotates feed the old carry into the vacated bit, shifts feed zero
    assign fill = ((op == OP_ROL) || (op == OP_ROR)) ? c_in : 1'b0;

    always_comb begin
        case (op)
            OP_LSR, OP_ROR: begin
                res   = {fill, a[W-1:1]};
                c_out = a[0];
            end
            default: begin
                res   = {a[W-2:0], fill};
                c_out = a[W-1];
            end
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          c_i,
    output logic [W-1:0]  res_o,
    output logic [3:0]    flags_o,
    output logic [3:0]    flag_we_o,
    output logic          res_we_o
);

    alu_op_e      op;
    logic [W-1:0] lg_res, ad_res, sh_res;
    logic         ad_c, ad_v, sh_c;

    logic [W-1:0] nxt_res;
    logic [3:0]   nxt_we;
    logic         nxt_rwe;
    logic         raw_n, raw_v, raw_z, raw_c;
    logic [3:0]   nxt_flags;
    logic         primed;

    assign op = alu_op_e'(op_i);

    alu8_logic #(.W(W)) u_logic (
        .op(op), .a(a_i), .b(b_i), .res(lg_res)
    );

    alu8_adder #(.W(W)) u_adder (
        .op(op), .a(a_i), .b(b_i), .c_in(c_i),
        .res(ad_res), .c_out(ad_c), .v_out(ad_v)
    );

    alu8_shift #(.W(W)) u_shift (
        .op(op), .a(a_i), .c_in(c_i),
        .res(sh_res), .c_out(sh_c)
    );

    // Result selection and per-operation flag rules
    always_comb begin
        nxt_res = '0;
        nxt_we  = WE_NONE;
        nxt_rwe = 1'b0;
        raw_c   = 1'b0;
        unique case (op)
            OP_AND, OP_OR, OP_XOR: begin
                nxt_res = lg_res; nxt_we = WE_NZ; nxt_rwe = 1'b1;
            end
            OP_BIT: begin
                nxt_res = lg_res; nxt_we = WE_NVZ;
            end
            OP_ADC, OP_SBC: begin
                nxt_res = ad_res; nxt_we = WE_ALL; nxt_rwe = 1'b1; raw_c = ad_c;
            end
            OP_CMP: begin
                nxt_res = ad_res; nxt_we = WE_NZC; raw_c = ad_c;
            end
            OP_INC, OP_DEC: begin
                nxt_res = ad_res; nxt_we = WE_NZ; nxt_rwe = 1'b1;
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                nxt_res = sh_res; nxt_we = WE_NZC; nxt_rwe = 1'b1; raw_c = sh_c;
            end
            default: begin
                nxt_res = '0; nxt_we = WE_NONE; nxt_rwe = 1'b0;
            end
        endcase
    end

    assign raw_n = (op == OP_BIT) ? b_i[W-1] : nxt_res[W-1];
    assign raw_v = (op == OP_BIT) ? b_i[W-2] : ad_v;
    assign raw_z = (nxt_res == '0);
    assign nxt_flags = {raw_n, raw_v, raw_z, raw_c} & nxt_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_o     <= '0;
            flags_o   <= '0;
            flag_we_o <= '0;
            res_we_o  <= 1'b0;
            primed    <= 1'b0;
        end else begin
            res_o     <= nxt_res;
            flags_o   <= nxt_flags;
            flag_we_o <= nxt_we;
            res_we_o  <= nxt_rwe;
            primed    <= 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (res_o == '0 && flags_o == '0 && flag_we_o == '0 && !res_we_o));

    // R13
    masked_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~flag_we_o) == 4'b0000);

    // R11
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o[FL_Z] |-> (flags_o[FL_Z] == (res_o == '0)));

    // R11
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_o[FL_N] && !flag_we_o[FL_C] && !flag_we_o[FL_V] && res_we_o)
        |-> (flags_o[FL_N] == res_o[W-1]));

    // R7
    cmp_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_i) == OP_CMP)
        |-> (flags_o[FL_C] == ($past(a_i) >= $past(b_i)) && !res_we_o));

    // R8
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
        |-> !flag_we_o[FL_C]);

    // R4
    bit_nv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_i) == OP_BIT)
        |-> (flags_o[FL_N] == $past(b_i[W-1]) && flags_o[FL_V] == $past(b_i[W-2])));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $stable(op_i) && $stable(a_i) && $stable(b_i) && $stable(c_i)
         && $past(primed)) |=> $stable(res_o));

endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] a_i = 8'd0;
    logic [7:0] b_i = 8'd0;
    logic       c_i = 1'b0;
    logic [7:0] res_o;
    logic [3:0] flags_o;
    logic [3:0] flag_we_o;
    logic       res_we_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    alu8_core u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
        .res_o(res_o), .flags_o(flags_o), .flag_we_o(flag_we_o), .res_we_o(res_we_o)
    );

    // Expected {res, flags, we, rwe} from the written rules
    function automatic logic [16:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic c);
        int s, sa, sb, ss;
        logic [7:0] r = 8'd0;
        logic n = 0, v = 0, cy = 0;
        logic [3:0] we = 4'b0000;
        logic rwe = 0;
        sa = $signed(a); sb = $signed(b);
        case (op)
            4'd0: begin r = a & b; we = 4'b1010; rwe = 1; end
            4'd1: begin r = a | b; we = 4'b1010; rwe = 1; end
            4'd2: begin r = a ^ b; we = 4'b1010; rwe = 1; end
            4'd3: begin r = a & b; we = 4'b1110; end
            4'd4: begin
                s = int'(a) + int'(b) + int'(c); r = s[7:0]; cy = (s > 255);
                ss = sa + sb + int'(c); v = (ss > 127) || (ss < -128);
                we = 4'b1111; rwe = 1;
            end
            4'd5: begin
                s = int'(a) - int'(b) - (1 - int'(c)); r = s[7:0]; cy = (s >= 0);
                ss = sa - sb - (1 - int'(c)); v = (ss > 127) || (ss < -128);
                we = 4'b1111; rwe = 1;
            end
            4'd6: begin
                s = int'(a) - int'(b); r = s[7:0]; cy = (a >= b); we = 4'b1011;
            end
            4'd7: begin s = int'(a) + 1; r = s[7:0]; we = 4'b1010; rwe = 1; end
            4'd8: begin s = int'(a) - 1; r = s[7:0]; we = 4'b1010; rwe = 1; end
            4'd9: begin s = int'(a) * 2; r = s[7:0]; cy = a[7]; we = 4'b1011; rwe = 1; end
            4'd10: begin r = a / 2; cy = a[0]; we = 4'b1011; rwe = 1; end
            4'd11: begin s = int'(a) * 2 + int'(c); r = s[7:0]; cy = a[7]; we = 4'b1011; rwe = 1; end
            4'd12: begin r = (a / 2) + (c ? 8'd128 : 8'd0); cy = a[0]; we = 4'b1011; rwe = 1; end
            default: begin r = 8'd0; we = 4'b0000; end
        endcase
        n = (op == 4'd3) ? b[7] : r[7];
        if (op == 4'd3) v = b[6];
        return {r, ({n, v, (r == 8'd0), cy} & we), we, rwe};
    endfunction

    task automatic check(input string tag, input logic [16:0] exp);
        logic [16:0] got;
        got = {res_o, flags_o, flag_we_o, res_we_o};
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got res=%h fl=%b we=%b rwe=%b exp res=%h fl=%b we=%b rwe=%b",
                     tag, got[16:9], got[8:5], got[4:1], got[0],
                     exp[16:9], exp[8:5], exp[4:1], exp[0]);
        end
    endtask

    task automatic apply(input string tag, input logic [3:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic c);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; c_i = c;
        @(negedge clk);
        check(tag, model(op, a, b, c));
    endtask

    task automatic t_reset();
        #1;
        check("R1 reset", 17'd0);
        op_i = 4'd4; a_i = 8'hFF; b_i = 8'hFF; c_i = 1'b1;
        @(negedge clk);
        check("R1 reset held", 17'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        apply("R2 first", 4'd1, 8'h0F, 8'hF0, 1'b0);
        @(negedge clk);
        op_i = 4'd2; a_i = 8'hFF; b_i = 8'h0F;
        #2;
        check("R2 before edge", model(4'd1, 8'h0F, 8'hF0, 1'b0));
        @(negedge clk);
        check("R2 after edge", model(4'd2, 8'hFF, 8'h0F, 1'b0));
    endtask

    task automatic t_logic();
        apply("R3 and", 4'd0, 8'hCC, 8'hAA, 1'b1);
        apply("R3 and zero", 4'd0, 8'hF0, 8'h0F, 1'b1);
        apply("R3 or neg", 4'd1, 8'h80, 8'h01, 1'b0);
        apply("R3 xor zero", 4'd2, 8'h5A, 8'h5A, 1'b1);
    endtask

    task automatic t_bit();
        apply("R4 bit zero nv", 4'd3, 8'h01, 8'hC0, 1'b0);
        apply("R4 bit nonzero", 4'd3, 8'h3F, 8'h21, 1'b1);
    endtask

    task automatic t_adc();
        apply("R5 adc overflow", 4'd4, 8'h50, 8'h50, 1'b0);
        apply("R5 adc carry zero", 4'd4, 8'hFF, 8'h01, 1'b0);
        apply("R5 adc carry in", 4'd4, 8'h7F, 8'h00, 1'b1);
        apply("R5 adc neg overflow", 4'd4, 8'h80, 8'hFF, 1'b0);
    endtask

    task automatic t_sbc();
        apply("R6 sbc no borrow", 4'd5, 8'h50, 8'h10, 1'b1);
        apply("R6 sbc borrow in", 4'd5, 8'h50, 8'h10, 1'b0);
        apply("R6 sbc overflow", 4'd5, 8'h50, 8'hB0, 1'b1);
        apply("R6 sbc underflow", 4'd5, 8'h00, 8'h01, 1'b1);
    endtask

    task automatic t_cmp();
        apply("R7 cmp equal", 4'd6, 8'h42, 8'h42, 1'b0);
        apply("R7 cmp greater", 4'd6, 8'h90, 8'h10, 1'b0);
        apply("R7 cmp less", 4'd6, 8'h10, 8'h90, 1'b1);
        apply("R7 cmp cin ignored", 4'd6, 8'h42, 8'h42, 1'b1);
    endtask

    task automatic t_incdec();
        apply("R8 inc wrap", 4'd7, 8'hFF, 8'h00, 1'b1);
        apply("R8 inc neg", 4'd7, 8'h7F, 8'h00, 1'b0);
        apply("R8 dec wrap", 4'd8, 8'h00, 8'h00, 1'b1);
        apply("R8 dec zero", 4'd8, 8'h01, 8'hFF, 1'b0);
    endtask

    task automatic t_shift();
        apply("R9 asl carry", 4'd9, 8'h81, 8'h00, 1'b1);
        apply("R9 asl zero", 4'd9, 8'h80, 8'h00, 1'b0);
        apply("R9 lsr carry", 4'd10, 8'h03, 8'h00, 1'b1);
        apply("R9 lsr fill", 4'd10, 8'hFE, 8'h00, 1'b1);
    endtask

    task automatic t_rotate();
        apply("R10 rol cin1", 4'd11, 8'h40, 8'h00, 1'b1);
        apply("R10 rol cin0", 4'd11, 8'h80, 8'h00, 1'b0);
        apply("R10 ror cin1", 4'd12, 8'h02, 8'h00, 1'b1);
        apply("R10 ror out", 4'd12, 8'h01, 8'h00, 1'b0);
    endtask

    task automatic t_nz();
        apply("R11 adc n", 4'd4, 8'h70, 8'h20, 1'b0);
        apply("R13 inc masks vc", 4'd7, 8'h7F, 8'h7F, 1'b1);
    endtask

    task automatic t_reserved();
        for (int k = 13; k < 16; k++) begin
            apply("R12 reserved", 4'(k), 8'hFF, 8'hFF, 1'b1);
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_logic();
        t_bit();
        t_adc();
        t_sbc();
        t_cmp();
        t_incdec();
        t_shift();
        t_rotate();
        t_nz();
        t_reserved();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule